// File: doc/BRIEF.md
# Synchronous SRAM Burst Address Sequencer

This block sits in front of a small synchronous memory array. It works like a no-turnaround SRAM that has its own burst counter. On every clock the bus issues one access. It either loads a fresh start address from the external address bus, or it advances an internal two-bit beat counter. The beat counter rewrites only the two low address bits. The upper bits stay as they were when the burst was loaded.

A static mode input chooses the order of the low bits. Linear order counts upward modulo four from the loaded value. Interleaved order XORs the loaded low bits with the beat number. Every access is tagged as a read or a write, and the address actually used is shown on the access outputs.

A second static mode input sets the data latency. In flow-through mode data moves one clock after the address edge. In pipelined mode it moves two clocks after. Write data uses the same latency as read data, so reads and writes can follow each other in any mix with no idle cycle between them.

Top module: `burstAddrSeq`

## Requirements
- R1: When `advance` is 0 at a clock edge, that edge starts a new burst. The access uses `extAddr` unchanged, shown on `accAddr` with `accValid`=1 after that edge.
- R2: With `interleave`=0, each edge with `advance`=1 gives low bits (loaded low bits + beat) mod 4, where beat is 1, 2, 3 after the load. Example: start 0x12 gives 0x12, 0x13, 0x10, 0x11.
- R3: With `interleave`=1, the low bits are the loaded low bits XOR beat. Example: start 0x25 gives 0x25, 0x24, 0x27, 0x26.
- R4: After four accesses (the load plus three advances), the next advance returns to the loaded address, and the sequence repeats.
- R5: Address bits above bit 1 keep the loaded value for the whole burst. No carry passes out of the two low bits.
- R6: `accWrite` follows `wrEn` sampled on the same edge as the access, for loads and advances alike. It does not inherit the type of the load.
- R7: An edge with `advance`=1 and no load since reset makes no access: `accValid`=0, no read data, no write.
- R8: With `pipelined`=0, a read shows `rdValid`=1 and its data during the clock right after its address edge. Write data is taken from `wrData` at the next edge.
- R9: With `pipelined`=1, read data and `rdValid` come one clock later than in R8. Write data is taken from `wrData` two edges after the address edge.
- R10: Reads and writes may alternate on every clock with no idle cycle. A read returns the data of the most recent earlier write to the same address, including a write in the cycle just before.
- R11: While and right after reset, `accValid` and `rdValid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| advance | input | 1 | 1: step the burst counter, 0: load `extAddr` |
| wrEn | input | 1 | 1: this access is a write |
| extAddr | input | ADDR_W | External start address |
| wrData | input | DATA_W | Write data, taken one or two edges after the access |
| interleave | input | 1 | Burst order: 0 linear, 1 XOR-interleaved (static) |
| pipelined | input | 1 | Data latency: 0 flow-through, 1 pipelined (static) |
| accValid | output | 1 | An access was issued on the last edge |
| accWrite | output | 1 | The issued access is a write |
| accAddr | output | ADDR_W | Address used by the issued access |
| rdValid | output | 1 | `rdData` carries read data |
| rdData | output | DATA_W | Read data |

## Verification
A wrong beat counter or base register shows up on `accAddr` one clock after the edge where it goes wrong. The bench therefore compares every issued address and type in the cycle it appears. A latency stage that is out of step shows as `rdValid` a clock too early or too late. A missing bypass shows as stale data on a read that directly follows a write to the same address. Both are visible within two clocks of the access. Memory corruption from a stray write shows only when that word is read back later, so the bench reads back every burst it writes.

// File: rtl/burstSeqPkg.sv
package burstSeqPkg;

  // Strobes handed from the control to the datapath each cycle
  typedef struct packed {
    logic       load;     // capture external address, restart burst
    logic       step;     // advance the burst counter
    logic       issue;    // an access happens this edge
    logic       isWrite;  // the access is a write
    logic [1:0] beat;     // beat number the access uses
  } seqStrobes_t;

  // Low two address bits for a given beat
  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       interleaveMode);
    logic [1:0] res;
    if (interleaveMode) res = start ^ beat;
    else                res = start + beat;
    return res;
  endfunction

endpackage

// File: rtl/burstCtrl.sv
module burstCtrl
  import burstSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        advance,
  input  logic        wrEn,
  output seqStrobes_t strb
);

  logic [1:0] beatQ;
  logic       loadedQ;

  always_comb begin
    strb.load    = !advance;
    strb.step    = advance && loadedQ;
    strb.issue   = strb.load || strb.step;
    strb.isWrite = strb.issue && wrEn;
    strb.beat    = strb.load ? 2'd0 : beatQ + 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      beatQ   <= 2'd0;
      loadedQ <= 1'b0;
    end else if (strb.issue) begin
      beatQ   <= strb.beat;
      loadedQ <= 1'b1;
    end
  end

  // R4: after the fourth beat the counter is back at the start
  p_wrap_four_r4: assert property (@(posedge clk) disable iff (!rstN)
    (advance && loadedQ && beatQ == 2'd3) |=> (beatQ == 2'd0));

  // R1: a load restarts the beat count and arms the burst
  p_load_restart_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!advance) |=> (beatQ == 2'd0 && loadedQ));

  // R7: advancing without any load leaves the sequencer unarmed
  p_unloaded_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (advance && !loadedQ) |=> (!loadedQ && beatQ == 2'd0));

endmodule

// File: rtl/sramArray.sv
module sramArray #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/burstDatapath.sv
module burstDatapath
  import burstSeqPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strb,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              interleave,
  input  logic              pipelined,
  output logic              accValid,
  output logic              accWrite,
  output logic [ADDR_W-1:0] accAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] baseQ;
  logic [ADDR_W-1:0] nextAddr;
  // stage A: the access issued on the last edge
  logic              aValid, aWrite;
  logic [ADDR_W-1:0] aAddr;
  // stage B: the access issued one edge earlier
  logic              bValid, bWrite;
  logic [ADDR_W-1:0] bAddr;

  logic              memWe;
  logic [ADDR_W-1:0] memWaddr;
  logic [DATA_W-1:0] memRdata;
  logic              pipeValidQ;
  logic [DATA_W-1:0] pipeDataQ;
  logic              bypassHit;

  always_comb begin
    if (strb.load) nextAddr = extAddr;
    else nextAddr = {baseQ[ADDR_W-1:2], burstLow(baseQ[1:0], strb.beat, interleave)};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ  <= '0;
      aValid <= 1'b0;
      aWrite <= 1'b0;
      aAddr  <= '0;
      bValid <= 1'b0;
      bWrite <= 1'b0;
      bAddr  <= '0;
    end else begin
      if (strb.load) baseQ <= extAddr;
      aValid <= strb.issue;
      aWrite <= strb.isWrite;
      if (strb.issue) aAddr <= nextAddr;
      bValid <= aValid;
      bWrite <= aWrite;
      bAddr  <= aAddr;
    end
  end

  // Write commit point follows the selected latency
  always_comb begin
    if (pipelined) begin
      memWe    = bValid && bWrite;
      memWaddr = bAddr;
    end else begin
      memWe    = aValid && aWrite;
      memWaddr = aAddr;
    end
  end

  sramArray #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_array (
    .clk   (clk),
    .we    (memWe),
    .waddr (memWaddr),
    .wdata (wrData),
    .raddr (aAddr),
    .rdata (memRdata)
  );

  // In pipelined mode the older write commits on the same edge the read is registered
  assign bypassHit = bValid && bWrite && (bAddr == aAddr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pipeValidQ <= 1'b0;
      pipeDataQ  <= '0;
    end else begin
      pipeValidQ <= aValid && !aWrite;
      if (aValid && !aWrite) pipeDataQ <= bypassHit ? wrData : memRdata;
    end
  end

  assign accValid = aValid;
  assign accWrite = aWrite;
  assign accAddr  = aAddr;
  assign rdValid  = pipelined ? pipeValidQ : (aValid && !aWrite);
  assign rdData   = pipelined ? pipeDataQ  : memRdata;

  // R1: a load puts the external address on the access bus
  p_load_addr_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> (accValid && accAddr == $past(extAddr)));

  // R5: upper bits never change during a burst
  p_upper_held_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.step |=> (accAddr[ADDR_W-1 -: HI_W] == $past(baseQ[ADDR_W-1 -: HI_W])));

  // R9: pipelined read data follows the access by one clock
  p_pipe_latency_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pipelined && $stable(pipelined) && accValid && !accWrite) |=> rdValid);

endmodule

// File: rtl/burstAddrSeq.sv
module burstAddrSeq #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              advance,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] extAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              interleave,
  input  logic              pipelined,
  output logic              accValid,
  output logic              accWrite,
  output logic [ADDR_W-1:0] accAddr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);

  burstSeqPkg::seqStrobes_t strb;

  burstCtrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .advance (advance),
    .wrEn    (wrEn),
    .strb    (strb)
  );

  burstDatapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .extAddr    (extAddr),
    .wrData     (wrData),
    .interleave (interleave),
    .pipelined  (pipelined),
    .accValid   (accValid),
    .accWrite   (accWrite),
    .accAddr    (accAddr),
    .rdValid    (rdValid),
    .rdData     (rdData)
  );

  // R6: the access type comes from wrEn on the access edge
  p_type_same_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!advance) |=> (accWrite == $past(wrEn)));

endmodule

// File: tb/test_burstAddrSeq.sv
module test_burstAddrSeq;

  localparam int AW = 6;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          advance = 1'b1;
  logic          wrEn = 1'b0;
  logic [AW-1:0] extAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          interleave = 1'b0;
  logic          pipelined = 1'b0;
  logic          accValid, accWrite, rdValid;
  logic [AW-1:0] accAddr;
  logic [DW-1:0] rdData;

  always #2 clk = ~clk;

  burstAddrSeq #(.ADDR_W(AW), .DATA_W(DW)) i_burstAddrSeq (
    .clk(clk), .rstN(rstN), .advance(advance), .wrEn(wrEn), .extAddr(extAddr),
    .wrData(wrData), .interleave(interleave), .pipelined(pipelined),
    .accValid(accValid), .accWrite(accWrite), .accAddr(accAddr),
    .rdValid(rdValid), .rdData(rdData)
  );

  typedef struct {
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    string         tag;
  } accExp_t;

  typedef struct {
    logic [DW-1:0] d;
    string         tag;
  } datExp_t;

  accExp_t       addrQ[$];
  datExp_t       dataQ[$];
  logic [DW-1:0] model [64];
  logic          mLoaded = 1'b0;
  logic [AW-1:0] mBase = '0;
  logic [1:0]    mBeat = '0;
  logic [DW-1:0] hist0 = '0, hist1 = '0;
  bit            inReset = 1'b1;
  bit            prevRd = 1'b0;
  int            nChecks = 0;
  int            nFail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Driver: one access per call, expectations pushed to the scoreboard
  task automatic step(input logic adv, input logic we, input logic [AW-1:0] addr,
                      input logic [DW-1:0] d, input string tag);
    accExp_t e;
    datExp_t x;
    logic [1:0] lo;
    @(negedge clk);
    advance = adv;
    wrEn    = we;
    extAddr = addr;
    wrData  = pipelined ? hist1 : hist0;
    hist1   = hist0;
    hist0   = d;
    e.v = 1'b0; e.w = 1'b0; e.a = '0; e.tag = tag;
    if (!adv) begin
      mLoaded = 1'b1; mBase = addr; mBeat = 2'd0;
      e.v = 1'b1; e.a = addr;
    end else if (mLoaded) begin
      mBeat = mBeat + 2'd1;
      lo = interleave ? (mBase[1:0] ^ mBeat) : (mBase[1:0] + mBeat);
      e.v = 1'b1; e.a = {mBase[AW-1:2], lo};
    end
    if (e.v) begin
      e.w = we;
      if (we) model[e.a] = d;
      else begin
        x.d = model[e.a]; x.tag = tag;
        dataQ.push_back(x);
      end
    end
    addrQ.push_back(e);
  endtask

  // Monitor: compares the access bus and read data one ns after each edge
  initial begin
    accExp_t e;
    datExp_t x;
    bit curRd, expRdv;
    forever begin
      @(posedge clk);
      #1;
      if (rstN && !inReset) begin
        curRd = 1'b0;
        if (addrQ.size() > 0) begin
          e = addrQ.pop_front();
          curRd = e.v && !e.w;
          chk(accValid === e.v, e.tag, "accValid", 32'(accValid), 32'(e.v));
          if (e.v) begin
            chk(accAddr === e.a, e.tag, "accAddr", 32'(accAddr), 32'(e.a));
            chk(accWrite === e.w, e.tag, "accWrite", 32'(accWrite), 32'(e.w));
          end
        end
        expRdv = pipelined ? prevRd : curRd;
        chk(rdValid === expRdv, pipelined ? "R9" : "R8", "rdValid timing",
            32'(rdValid), 32'(expRdv));
        prevRd = curRd;
        if (rdValid === 1'b1) begin
          if (dataQ.size() == 0) chk(1'b0, "R7", "unexpected read data", 32'(rdData), 32'h0);
          else begin
            x = dataQ.pop_front();
            if (!$isunknown(x.d))
              chk(rdData === x.d, x.tag, "rdData", 32'(rdData), 32'(x.d));
          end
        end
      end
    end
  end

  task automatic doReset(input logic il, input logic pl);
    inReset = 1'b1;
    @(negedge clk);
    rstN = 1'b0;
    addrQ.delete();
    dataQ.delete();
    interleave = il;
    pipelined  = pl;
    advance = 1'b1; wrEn = 1'b0;
    mLoaded = 1'b0; hist0 = '0; hist1 = '0; prevRd = 1'b0;
    @(negedge clk);
    chk(accValid === 1'b0 && rdValid === 1'b0, "R11", "outputs in reset",
        {rdValid, accValid}, 32'h0);
    rstN = 1'b1;
    inReset = 1'b0;
    @(posedge clk); #1;
    chk(accValid === 1'b0 && rdValid === 1'b0, "R11", "outputs after reset",
        {rdValid, accValid}, 32'h0);
  endtask

  // Flush: writes to a scratch word so all earlier reads drain
  task automatic endPhase();
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 6'h3F, 'x, "R10");
    @(posedge clk); #2;
    chk(dataQ.size() == 0, "R10", "reads drained", dataQ.size(), 32'h0);
  endtask

  initial begin
    #(4 * 20000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 'x;

    // Phase 1: linear, flow-through
    doReset(1'b0, 1'b0);
    step(1'b1, 1'b1, 6'h0A, 16'hDEAD, "R7");
    step(1'b1, 1'b0, 6'h0B, 16'h0, "R7");
    step(1'b0, 1'b1, 6'h12, 16'hA001, "R1");
    step(1'b1, 1'b1, 6'h00, 16'hA002, "R2");
    step(1'b1, 1'b1, 6'h00, 16'hA003, "R5");
    step(1'b1, 1'b1, 6'h00, 16'hA004, "R2");
    step(1'b0, 1'b0, 6'h12, 16'h0, "R8");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R2");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R5");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R2");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R4");
    step(1'b0, 1'b1, 6'h05, 16'hB001, "R6");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R6");
    step(1'b1, 1'b1, 6'h00, 16'hB002, "R6");
    step(1'b0, 1'b0, 6'h07, 16'h0, "R10");
    step(1'b0, 1'b1, 6'h20, 16'hC001, "R10");
    step(1'b0, 1'b0, 6'h20, 16'h0, "R10");
    endPhase();

    // Phase 2: interleaved, pipelined
    doReset(1'b1, 1'b1);
    step(1'b1, 1'b0, 6'h01, 16'h0, "R7");
    step(1'b0, 1'b1, 6'h26, 16'hD001, "R1");
    step(1'b1, 1'b1, 6'h00, 16'hD002, "R3");
    step(1'b1, 1'b1, 6'h00, 16'hD003, "R3");
    step(1'b1, 1'b1, 6'h00, 16'hD004, "R3");
    step(1'b0, 1'b0, 6'h25, 16'h0, "R9");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R4");
    step(1'b0, 1'b1, 6'h30, 16'hE001, "R10");
    step(1'b0, 1'b0, 6'h30, 16'h0, "R10");
    step(1'b1, 1'b1, 6'h00, 16'hE002, "R6");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R6");
    step(1'b0, 1'b0, 6'h31, 16'h0, "R10");
    endPhase();

    // Phase 3: interleaved, flow-through, start at low bits 3
    doReset(1'b1, 1'b0);
    step(1'b0, 1'b0, 6'h13, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R3");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R4");
    endPhase();

    // Phase 4: linear, pipelined
    doReset(1'b0, 1'b1);
    step(1'b0, 1'b0, 6'h26, 16'h0, "R9");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R2");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R5");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R2");
    step(1'b0, 1'b1, 6'h07, 16'hF001, "R10");
    step(1'b1, 1'b0, 6'h00, 16'h0, "R5");
    step(1'b0, 1'b0, 6'h07, 16'h0, "R10");
    endPhase();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule